// File: doc/BRIEF.md
# AHB-Lite Machine Timer and Interrupt Register Block

This block is an AHB-Lite slave that gives a processor a free-running 64-bit machine time counter with a 64-bit compare value. It raises a timer interrupt whenever the count has reached the compare value. The same slave also holds three other kinds of state. The first is a software interrupt level. The second is a 32-bit external interrupt vector, which software changes through separate set and clear addresses. The third is a sticky exit request that stores a code.

Every register is a 32-bit word. An access to any address outside the map gets the standard two-cycle AHB error response. The outputs are plain levels, so a core, or a bench that stands in for one, can wire them straight to its interrupt inputs and stop condition.

Top module: `ahb_mtimer_irq`

## Requirements
- R1: After reset the count is 0 and the compare value is all ones. The irq vector, soft_irq, exit_req and exit_code are 0, HREADY is 1 and HRESP is 0.
- R2: The count rises by one on every clock. Offset 0x100 reads its bits 31:0 and offset 0x104 reads its bits 63:32.
- R3: timer_irq is 1 exactly when the count is greater than or equal to the compare value, compared as unsigned 64-bit numbers. This includes the cycles around the wrap of the count from all ones to zero.
- R4: The compare value is written as two halves, bits 31:0 at 0x108 and bits 63:32 at 0x10C. Writing either half of the count or of the compare value leaves the other half unchanged, and reads return the half that was addressed.
- R5: In a cycle where software writes a half of the count, the count takes the written half and the old other half, with no increment. Counting resumes on the next cycle.
- R6: A write to 0x018 ORs the write data into irq. A write to 0x01C clears each irq bit that is 1 in the write data. A read of either address returns irq.
- R7: A write to 0x010 sets soft_irq and a write to 0x014 clears it. A read of either address returns soft_irq in bit 0, with bits 31:1 zero.
- R8: The first write to 0x008 sets exit_req and stores the write data in exit_code. Later writes change neither. A read of 0x008 returns exit_code.
- R9: An access to an unmapped address takes two data-phase cycles. The first has HREADY=0 and HRESP=1, the second has HREADY=1 and HRESP=1, and no register changes. Mapped offsets are 0x008 and 0x010 to 0x01C in steps of 4, and 0x100 to 0x10C in steps of 4. The offset is in address bits 11:0, and bits 31:12 must equal those of the base address 0x8000_0000. With the default strict alignment, an address whose bits 1:0 are not zero is unmapped.
- R10: An address phase is accepted only in a cycle where HREADY is 1 and HTRANS[1] is 1. IDLE (00) and BUSY (01) transfers have no effect. Write data is taken from HWDATA in the cycle after the address phase.
- R11: HEXOKAY is 1 whenever HRESP is 0, and 0 during both error cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| haddr | input | 32 | AHB address |
| htrans | input | 2 | AHB transfer type |
| hwrite | input | 1 | AHB write enable |
| hsize | input | 3 | AHB transfer size (registers are word-wide; not decoded) |
| hwdata | input | 32 | AHB write data |
| hrdata | output | 32 | AHB read data |
| hready | output | 1 | Slave ready, also the bus-wide ready seen by this slave |
| hresp | output | 1 | Error response |
| hexokay | output | 1 | Okay indicator on normal responses |
| timer_irq | output | 1 | Count has reached the compare value |
| soft_irq | output | 1 | Software interrupt level |
| irq | output | 32 | External interrupt vector |
| exit_req | output | 1 | Sticky exit request |
| exit_code | output | 32 | Code captured by the first exit write |

## Verification
The bench builds the block with its defaults: 32-bit data, a 64-bit count, a 32-bit irq vector, base address 0x8000_0000 and strict alignment. Because the irq vector is as wide as the data bus, every write-data bit reaches an irq bit, so set and clear patterns over all 32 bits are covered. Because alignment is strict, an access with address bits 1:0 not zero can be driven and must get the error response, next to the cases of an unmapped offset and a wrong base. The default widths also let the bench load the count with values just below the 64-bit wrap and just below a carry out of the low half, so the compare and the half-write priority are seen at both boundaries.

// File: rtl/tiu_pkg.sv
package tiu_pkg;

   localparam int TIU_OFS_W = 12;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_EXIT,
      SEL_SOFT_SET,
      SEL_SOFT_CLR,
      SEL_IRQ_SET,
      SEL_IRQ_CLR,
      SEL_TIME_LO,
      SEL_TIME_HI,
      SEL_CMP_LO,
      SEL_CMP_HI
   } tiu_sel_e;

   localparam logic [TIU_OFS_W-1:0] OFS_EXIT     = 12'h008;
   localparam logic [TIU_OFS_W-1:0] OFS_SOFT_SET = 12'h010;
   localparam logic [TIU_OFS_W-1:0] OFS_SOFT_CLR = 12'h014;
   localparam logic [TIU_OFS_W-1:0] OFS_IRQ_SET  = 12'h018;
   localparam logic [TIU_OFS_W-1:0] OFS_IRQ_CLR  = 12'h01C;
   localparam logic [TIU_OFS_W-1:0] OFS_TIME_LO  = 12'h100;
   localparam logic [TIU_OFS_W-1:0] OFS_TIME_HI  = 12'h104;
   localparam logic [TIU_OFS_W-1:0] OFS_CMP_LO   = 12'h108;
   localparam logic [TIU_OFS_W-1:0] OFS_CMP_HI   = 12'h10C;

   // Word offset to register select; anything else is unmapped.
   function automatic tiu_sel_e tiu_decode(input logic [TIU_OFS_W-1:0] ofs);
      tiu_sel_e s;
      case (ofs)
         OFS_EXIT:     s = SEL_EXIT;
         OFS_SOFT_SET: s = SEL_SOFT_SET;
         OFS_SOFT_CLR: s = SEL_SOFT_CLR;
         OFS_IRQ_SET:  s = SEL_IRQ_SET;
         OFS_IRQ_CLR:  s = SEL_IRQ_CLR;
         OFS_TIME_LO:  s = SEL_TIME_LO;
         OFS_TIME_HI:  s = SEL_TIME_HI;
         OFS_CMP_LO:   s = SEL_CMP_LO;
         OFS_CMP_HI:   s = SEL_CMP_HI;
         default:      s = SEL_NONE;
      endcase
      return s;
   endfunction

   // Select for half h of the count (is_cmp=0) or of the compare value.
   function automatic tiu_sel_e tiu_half_sel(input int h, input bit is_cmp);
      if (is_cmp) return (h == 0) ? SEL_CMP_LO : SEL_CMP_HI;
      return (h == 0) ? SEL_TIME_LO : SEL_TIME_HI;
   endfunction

endpackage

// File: rtl/tiu_ahb_front.sv
module tiu_ahb_front
   import tiu_pkg::*;
#(
   parameter int              ADDR_W       = 32,
   parameter int              DATA_W       = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h8000_0000,
   parameter bit              STRICT_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [1:0]        htrans,
   input  logic              hwrite,
   input  logic [2:0]        hsize,
   input  logic [DATA_W-1:0] hwdata,
   output logic              hready,
   output logic              hresp,
   output logic              hexokay,
   output logic              wr_en,
   output logic              rd_en,
   output tiu_sel_e          acc_sel,
   output logic [DATA_W-1:0] wr_data
);

   localparam int HI_W = ADDR_W - TIU_OFS_W;

   logic     align_ok;
   logic     base_ok;
   tiu_sel_e sel_a;

   logic     dp_valid_q;
   logic     dp_write_q;
   tiu_sel_e dp_sel_q;
   logic     err2_q;
   logic     err1;

   logic     unused_front;
   assign unused_front = ^{hsize, htrans[0]};

   generate
      if (STRICT_ALIGN) begin : g_strict
         assign align_ok = (haddr[1:0] == 2'b00);
      end else begin : g_loose
         assign align_ok = 1'b1;
      end
   endgenerate

   assign base_ok = (haddr[ADDR_W-1:TIU_OFS_W] == BASE_ADDR[ADDR_W-1:TIU_OFS_W]);
   assign sel_a   = (base_ok && align_ok)
                  ? tiu_decode({haddr[TIU_OFS_W-1:2], 2'b00}) : SEL_NONE;

   // First error cycle: data phase of an unmapped access.
   assign err1    = dp_valid_q && (dp_sel_q == SEL_NONE);
   assign hready  = !err1;
   assign hresp   = err1 || err2_q;
   assign hexokay = !hresp;

   assign wr_en   = dp_valid_q && dp_write_q && !err1;
   assign rd_en   = dp_valid_q && !dp_write_q && !err1;
   assign acc_sel = dp_sel_q;
   assign wr_data = hwdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_valid_q <= 1'b0;
         dp_write_q <= 1'b0;
         dp_sel_q   <= SEL_NONE;
         err2_q     <= 1'b0;
      end else if (err1) begin
         dp_valid_q <= 1'b0;
         err2_q     <= 1'b1;
      end else begin
         err2_q     <= 1'b0;
         dp_valid_q <= htrans[1];
         if (htrans[1]) begin
            dp_write_q <= hwrite;
            dp_sel_q   <= sel_a;
         end
      end
   end

endmodule

// File: rtl/tiu_mtimer.sv
module tiu_mtimer
   import tiu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  tiu_sel_e          wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [TIME_W-1:0] mtime,
   output logic [TIME_W-1:0] mtimecmp,
   output logic              time_wr,
   output logic              timer_irq
);

   localparam int NHALF = TIME_W / DATA_W;

   logic [TIME_W-1:0] time_q;
   logic [TIME_W-1:0] time_nxt;
   logic [NHALF-1:0]  t_hit;
   logic [NHALF-1:0]  c_hit;

   generate
      for (genvar h = 0; h < NHALF; h++) begin : g_half
         localparam tiu_sel_e TSEL = tiu_half_sel(h, 1'b0);
         localparam tiu_sel_e CSEL = tiu_half_sel(h, 1'b1);
         logic [DATA_W-1:0] cmp_h;

         assign t_hit[h] = wr_en && (wr_sel == TSEL);
         assign c_hit[h] = wr_en && (wr_sel == CSEL);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cmp_h <= '1;
            else if (c_hit[h]) cmp_h <= wr_data;
         end

         assign mtimecmp[h*DATA_W +: DATA_W] = cmp_h;
      end
   endgenerate

   assign time_wr = |t_hit;

   // A half write replaces the increment for that cycle.
   always_comb begin
      time_nxt = time_wr ? time_q : time_q + 1'b1;
      for (int h = 0; h < NHALF; h++) begin
         if (t_hit[h]) time_nxt[h*DATA_W +: DATA_W] = wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) time_q <= '0;
      else        time_q <= time_nxt;
   end

   assign mtime     = time_q;
   assign timer_irq = (time_q >= mtimecmp);

endmodule

// File: rtl/tiu_irq_regs.sv
module tiu_irq_regs
   import tiu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IRQ_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  tiu_sel_e          wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [IRQ_W-1:0]  irq,
   output logic              soft_irq,
   output logic              exit_req,
   output logic [DATA_W-1:0] exit_code,
   output logic              irq_clr_wr
);

   logic [IRQ_W-1:0]  irq_q;
   logic              soft_q;
   logic              exit_q;
   logic [DATA_W-1:0] code_q;
   logic              irq_set_wr;

   assign irq_set_wr = wr_en && (wr_sel == SEL_IRQ_SET);
   assign irq_clr_wr = wr_en && (wr_sel == SEL_IRQ_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= '0;
      end else if (irq_set_wr) begin
         irq_q <= irq_q | wr_data[IRQ_W-1:0];
      end else if (irq_clr_wr) begin
         irq_q <= irq_q & ~wr_data[IRQ_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_q <= 1'b0;
      end else if (wr_en && (wr_sel == SEL_SOFT_SET)) begin
         soft_q <= 1'b1;
      end else if (wr_en && (wr_sel == SEL_SOFT_CLR)) begin
         soft_q <= 1'b0;
      end
   end

   // First write wins; the request never falls once set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exit_q <= 1'b0;
         code_q <= '0;
      end else if (wr_en && (wr_sel == SEL_EXIT) && !exit_q) begin
         exit_q <= 1'b1;
         code_q <= wr_data;
      end
   end

   assign irq       = irq_q;
   assign soft_irq  = soft_q;
   assign exit_req  = exit_q;
   assign exit_code = code_q;

endmodule

// File: rtl/ahb_mtimer_irq.sv
module ahb_mtimer_irq
   import tiu_pkg::*;
#(
   parameter int                ADDR_W       = 32,
   parameter int                DATA_W       = 32,
   parameter int                TIME_W       = 64,
   parameter int                IRQ_W        = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR    = 32'h8000_0000,
   parameter bit                STRICT_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [1:0]        htrans,
   input  logic              hwrite,
   input  logic [2:0]        hsize,
   input  logic [DATA_W-1:0] hwdata,
   output logic [DATA_W-1:0] hrdata,
   output logic              hready,
   output logic              hresp,
   output logic              hexokay,
   output logic              timer_irq,
   output logic              soft_irq,
   output logic [IRQ_W-1:0]  irq,
   output logic              exit_req,
   output logic [DATA_W-1:0] exit_code
);

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("ahb_mtimer_irq: DATA_W must be 32");
      end
      if (TIME_W != 2 * DATA_W) begin : g_bad_time
         $error("ahb_mtimer_irq: TIME_W must be twice DATA_W");
      end
      if (IRQ_W < 1 || IRQ_W > DATA_W) begin : g_bad_irq
         $error("ahb_mtimer_irq: IRQ_W must be 1..DATA_W");
      end
      if (ADDR_W <= TIU_OFS_W) begin : g_bad_addr
         $error("ahb_mtimer_irq: ADDR_W too small for the offset field");
      end
      if (BASE_ADDR[TIU_OFS_W-1:0] != '0) begin : g_bad_base
         $error("ahb_mtimer_irq: BASE_ADDR must be 4 KiB aligned");
      end
   endgenerate

   logic              wr_en;
   logic              rd_en;
   tiu_sel_e          acc_sel;
   logic [DATA_W-1:0] wr_data;
   logic [TIME_W-1:0] mtime_val;
   logic [TIME_W-1:0] mtimecmp_val;
   logic              time_wr;
   logic              irq_clr_wr;

   tiu_ahb_front #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .BASE_ADDR    (BASE_ADDR),
      .STRICT_ALIGN (STRICT_ALIGN)
   ) u_front (
      .clk     (clk),
      .rst_n   (rst_n),
      .haddr   (haddr),
      .htrans  (htrans),
      .hwrite  (hwrite),
      .hsize   (hsize),
      .hwdata  (hwdata),
      .hready  (hready),
      .hresp   (hresp),
      .hexokay (hexokay),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .acc_sel (acc_sel),
      .wr_data (wr_data)
   );

   tiu_mtimer #(
      .DATA_W (DATA_W),
      .TIME_W (TIME_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (acc_sel),
      .wr_data   (wr_data),
      .mtime     (mtime_val),
      .mtimecmp  (mtimecmp_val),
      .time_wr   (time_wr),
      .timer_irq (timer_irq)
   );

   tiu_irq_regs #(
      .DATA_W (DATA_W),
      .IRQ_W  (IRQ_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (acc_sel),
      .wr_data    (wr_data),
      .irq        (irq),
      .soft_irq   (soft_irq),
      .exit_req   (exit_req),
      .exit_code  (exit_code),
      .irq_clr_wr (irq_clr_wr)
   );

   // Read data is live during the data phase of a mapped read.
   always_comb begin
      hrdata = '0;
      if (rd_en) begin
         case (acc_sel)
            SEL_EXIT:                  hrdata = exit_code;
            SEL_SOFT_SET, SEL_SOFT_CLR: hrdata = {{(DATA_W-1){1'b0}}, soft_irq};
            SEL_IRQ_SET, SEL_IRQ_CLR:  hrdata[IRQ_W-1:0] = irq;
            SEL_TIME_LO:               hrdata = mtime_val[DATA_W-1:0];
            SEL_TIME_HI:               hrdata = mtime_val[TIME_W-1:DATA_W];
            SEL_CMP_LO:                hrdata = mtimecmp_val[DATA_W-1:0];
            SEL_CMP_HI:                hrdata = mtimecmp_val[TIME_W-1:DATA_W];
            default:                   hrdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/tiu_checker.sv
module tiu_checker #(
   parameter int DATA_W = 32,
   parameter int TIME_W = 64,
   parameter int IRQ_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hready,
   input logic              hresp,
   input logic              hexokay,
   input logic              exit_req,
   input logic [DATA_W-1:0] exit_code,
   input logic [TIME_W-1:0] mtime,
   input logic              time_wr,
   input logic [IRQ_W-1:0]  irq,
   input logic              irq_clr_wr
);

   // R9: a stalled cycle is always the first half of an error.
   p_err_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hready |-> hresp);

   // R9: the first error cycle is always followed by the second.
   p_err_second_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hready |=> (hready && hresp));

   // R11: an okay response carries HEXOKAY.
   p_okay_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !hresp |-> hexokay);

   // R8: once requested, the exit stays and its code is frozen.
   p_exit_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exit_req |=> (exit_req && $stable(exit_code)));

   // R2: without a software write the count steps by exactly one.
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(time_wr)) |-> (mtime == $past(mtime) + 1'b1));

   // R6: irq bits only fall after a clear write.
   p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(irq_clr_wr)) |-> (($past(irq) & ~irq) == '0));

endmodule

bind ahb_mtimer_irq tiu_checker #(
   .DATA_W (DATA_W),
   .TIME_W (TIME_W),
   .IRQ_W  (IRQ_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hready     (hready),
   .hresp      (hresp),
   .hexokay    (hexokay),
   .exit_req   (exit_req),
   .exit_code  (exit_code),
   .mtime      (mtime_val),
   .time_wr    (time_wr),
   .irq        (irq),
   .irq_clr_wr (irq_clr_wr)
);

// File: tb/ahb_mtimer_irq_bench.sv
module ahb_mtimer_irq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] haddr = '0;
   logic [1:0]  htrans = 2'b00;
   logic        hwrite = 1'b0;
   logic [2:0]  hsize = 3'b010;
   logic [31:0] hwdata = '0;
   logic [31:0] hrdata;
   logic        hready, hresp, hexokay;
   logic        timer_irq, soft_irq, exit_req;
   logic [31:0] irq, exit_code;

   always #5 clk = ~clk;

   ahb_mtimer_irq u_ahb_mtimer_irq (
      .clk(clk), .rst_n(rst_n), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
      .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
      .hresp(hresp), .hexokay(hexokay), .timer_irq(timer_irq),
      .soft_irq(soft_irq), .irq(irq), .exit_req(exit_req), .exit_code(exit_code)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic [63:0] m_time, m_cmp;
   logic [31:0] m_irq, m_code, m_dpa;
   bit          m_soft, m_exit, m_dpv, m_dpw, m_err2;

   function automatic bit m_hit(input logic [31:0] a);
      if (a[31:12] != 20'h80000 || a[1:0] != 2'b00) return 0;
      case (a[11:0])
         12'h008, 12'h010, 12'h014, 12'h018, 12'h01C,
         12'h100, 12'h104, 12'h108, 12'h10C: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] m_read(input logic [31:0] a);
      case (a[11:0])
         12'h008: return m_code;
         12'h010, 12'h014: return {31'd0, m_soft};
         12'h018, 12'h01C: return m_irq;
         12'h100: return m_time[31:0];
         12'h104: return m_time[63:32];
         12'h108: return m_cmp[31:0];
         default: return m_cmp[63:32];
      endcase
   endfunction

   function automatic string m_tag(input logic [31:0] a);
      case (a[11:0])
         12'h008: return "R8 exit read";
         12'h010, 12'h014: return "R7 soft read";
         12'h018, 12'h01C: return "R6 irq read";
         12'h100, 12'h104: return "R2 count read";
         default: return "R4 compare read";
      endcase
   endfunction

   task automatic m_init();
      m_time = '0; m_cmp = '1; m_irq = '0; m_code = '0; m_dpa = '0;
      m_soft = 0; m_exit = 0; m_dpv = 0; m_dpw = 0; m_err2 = 0;
   endtask

   initial m_init();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_init();
      end else begin
         bit e1, tw;
         e1 = m_dpv && !m_hit(m_dpa);
         tw = 0;
         if (m_dpv && !e1 && m_dpw) begin
            case (m_dpa[11:0])
               12'h008: if (!m_exit) begin m_exit = 1; m_code = hwdata; end
               12'h010: m_soft = 1;
               12'h014: m_soft = 0;
               12'h018: m_irq = m_irq | hwdata;
               12'h01C: m_irq = m_irq & ~hwdata;
               12'h100: begin m_time = {m_time[63:32], hwdata}; tw = 1; end
               12'h104: begin m_time = {hwdata, m_time[31:0]}; tw = 1; end
               12'h108: m_cmp = {m_cmp[63:32], hwdata};
               default: m_cmp = {hwdata, m_cmp[31:0]};
            endcase
         end
         if (!tw) m_time = m_time + 64'd1;
         if (e1) begin
            m_dpv = 0; m_err2 = 1;
         end else begin
            m_err2 = 0;
            m_dpv = htrans[1];
            if (htrans[1]) begin m_dpw = hwrite; m_dpa = haddr; end
         end
      end
   end

   // Compare every cycle, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e1;
         e1 = m_dpv && !m_hit(m_dpa);
         chk("R9 hready", hready, !e1);
         chk("R9 hresp", hresp, e1 || m_err2);
         chk("R11 hexokay", hexokay, !(e1 || m_err2));
         chk("R3 timer_irq", timer_irq, m_time >= m_cmp);
         chk("R6 R10 irq", irq, m_irq);
         chk("R7 soft_irq", soft_irq, m_soft);
         chk("R8 exit_req", exit_req, m_exit);
         chk("R8 exit_code", exit_code, m_code);
         if (m_dpv && !m_dpw && !e1) chk(m_tag(m_dpa), hrdata, m_read(m_dpa));
      end
   end

   // ---------------- stimulus ----------------
   task automatic xfer(input bit w, input logic [31:0] a, input logic [31:0] d,
                       input logic [1:0] tr = 2'b10);
      @(negedge clk);
      haddr = a; hwrite = w; htrans = tr;
      @(negedge clk);
      htrans = 2'b00; hwdata = d;
      while (!hready) @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d);
      xfer(1'b1, a, d);
   endtask

   task automatic rd(input logic [31:0] a);
      xfer(1'b0, a, 32'h0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
         finish_run();
      end
   end

   localparam logic [31:0] B = 32'h8000_0000;

   initial begin
      // R1: reset values seen at the ports while reset is held
      repeat (3) @(negedge clk);
      chk("R1 hready", hready, 1);
      chk("R1 hresp", hresp, 0);
      chk("R1 timer_irq", timer_irq, 0);
      chk("R1 irq", irq, 0);
      chk("R1 soft_irq", soft_irq, 0);
      chk("R1 exit_req", exit_req, 0);
      chk("R1 exit_code", exit_code, 0);
      rst_n = 1'b1;

      // R1, R2: count and reset compare value read back
      rd(B + 32'h100); rd(B + 32'h104); idle(5); rd(B + 32'h100);
      rd(B + 32'h108); rd(B + 32'h10C);

      // R4: half writes of the compare value; R3: crossing
      wr(B + 32'h108, 32'h0000_0080);
      rd(B + 32'h10C);
      wr(B + 32'h10C, 32'h0);
      rd(B + 32'h108);
      idle(120);

      // R5: half writes of the count win over the increment
      wr(B + 32'h104, 32'h0000_0001);
      wr(B + 32'h100, 32'hFFFF_FFF0);
      rd(B + 32'h100); rd(B + 32'h104);
      idle(20);
      rd(B + 32'h104);

      // R3: count below, then at, the compare value
      wr(B + 32'h10C, 32'h0000_0002);
      wr(B + 32'h108, 32'h0000_0010);
      wr(B + 32'h104, 32'h0000_0001);
      wr(B + 32'h100, 32'hFFFF_FFF0);
      wr(B + 32'h104, 32'h0000_0002);
      wr(B + 32'h100, 32'h0000_0000);
      idle(20);

      // R3: wrap of the full count past all ones
      wr(B + 32'h108, 32'hFFFF_FFFF);
      wr(B + 32'h10C, 32'hFFFF_FFFF);
      wr(B + 32'h104, 32'hFFFF_FFFF);
      wr(B + 32'h100, 32'hFFFF_FFF4);
      idle(20);
      rd(B + 32'h104);

      // R6: set and clear the irq vector
      wr(B + 32'h018, 32'hA5A5_0F0F);
      wr(B + 32'h018, 32'h1000_0000);
      wr(B + 32'h01C, 32'h0000_000F);
      rd(B + 32'h018); rd(B + 32'h01C);
      wr(B + 32'h01C, 32'hFFFF_FFFF);
      rd(B + 32'h018);

      // R7: software interrupt level
      wr(B + 32'h010, 32'h0);
      rd(B + 32'h014);
      wr(B + 32'h014, 32'hFFFF_FFFF);
      rd(B + 32'h010);
      wr(B + 32'h010, 32'h0);

      // R8: first exit write wins
      rd(B + 32'h008);
      wr(B + 32'h008, 32'h0000_002A);
      wr(B + 32'h008, 32'h0000_0099);
      rd(B + 32'h008);

      // R9: unmapped offset, misaligned, wrong base, read and write
      rd(B + 32'h200);
      wr(B + 32'h000, 32'h1234_5678);
      wr(B + 32'h019, 32'hFFFF_FFFF);
      wr(32'h4000_0018, 32'hFFFF_FFFF);
      rd(B + 32'h018);
      rd(B + 32'h104);

      // R10: IDLE and BUSY transfers must not write
      xfer(1'b1, B + 32'h018, 32'h0000_FFFF, 2'b00);
      xfer(1'b1, B + 32'h018, 32'h0000_FFFF, 2'b01);
      xfer(1'b1, B + 32'h014, 32'h0, 2'b01);
      rd(B + 32'h018);
      rd(B + 32'h010);

      // R10: write data sampled in the data phase, not the address phase
      @(negedge clk);
      haddr = B + 32'h018; hwrite = 1; htrans = 2'b10; hwdata = 32'hFFFF_FFFF;
      @(negedge clk);
      htrans = 2'b00; hwdata = 32'h0000_0100;
      @(negedge clk);
      rd(B + 32'h01C);
      idle(4);

      finish_run();
   end

endmodule